// File: doc/BRIEF.md
# Vertical Sync Output Selector

This block drives the vertical-sync output pin of a video encoder. Four configuration bits choose the source. Two are output enables, one for the SD path and one for the ED/HD path. The other two pick the ED/HD sync method: passthrough, embedded-code, or counter-generated. The source is one of the following:

- the SD timing engine's VSYNC/field signal,
- the ED/HD VSYNC/field input,
- the F or V bit decoded from embedded timing reference codes,
- a pulse built from the ED/HD vertical line counter.

Two live inputs also shape the result: the scan type (interlaced or progressive) and a 525p flag.

The configuration bits are captured into a shadow register only on a frame-boundary strobe. This stops a mode change from cutting a pulse short on the pin. The chosen sync level and the pin's output enable then travel through a fixed pipeline of `DEPTH` registers, so the pin lines up with the video data path.

The pin is active high. When both enables are off, the output enable is low and the sync level is held at 0.

Top module: `vsync_out_sel`

## Requirements
- R1: While reset is asserted, and after it is released until the first frame-boundary strobe, `vsync_oe_o` and `vsync_o` are both 0.
- R2: With the captured ED/HD enable and SD enable both 0, `vsync_oe_o` is 0 and `vsync_o` is 0 (pin three-stated).
- R3: With the captured ED/HD enable 0 and SD enable 1, `vsync_oe_o` is 1 and `vsync_o` follows `sd_vsync_i`.
- R4: With the captured ED/HD enable 1, the SD enable has no effect on either output.
- R5: With the ED/HD enable 1, format bit 0 and counter-select bit 0, `vsync_o` follows `edhd_vsync_i`.
- R6: With the ED/HD enable 1, format bit 1, counter-select 0 and `std_interlaced_i` 1, `vsync_o` follows the embedded-code F bit `code_f_i`.
- R7: With the ED/HD enable 1, format bit 1, counter-select 0 and `std_interlaced_i` 0, `vsync_o` follows the embedded-code V bit `code_v_i`.
- R8: With the ED/HD enable 1, counter-select 1 and `std_525p_i` 1, `vsync_o` is 1 exactly when `line_cnt_i` lies in [`VBI_FIRST`, `VBI_LAST`] inclusive (defaults 1 and 42), whatever the format bit.
- R9: With the ED/HD enable 1, counter-select 1 and `std_525p_i` 0, `vsync_o` is 1 exactly when `line_cnt_i` lies in [`SER_FIRST`, `SER_LAST`] inclusive (defaults 4 and 6), whatever the format bit.
- R10: The outputs reflect the inputs sampled `DEPTH` rising edges earlier (default 3): a change applied before edge k shows after edge k+DEPTH-1.
- R11: The configuration inputs are captured only on a rising edge where `frame_start_i` is 1. Changes at any other time have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start_i | input | 1 | Frame-boundary strobe; loads the configuration shadow |
| cfg_edhd_en_i | input | 1 | ED/HD sync output enable |
| cfg_sd_en_i | input | 1 | SD sync output enable |
| cfg_fmt_i | input | 1 | ED/HD sync format: 0 passthrough, 1 embedded-code bits |
| cfg_vctl_i | input | 1 | 1 selects counter-generated ED/HD VSYNC |
| std_interlaced_i | input | 1 | Active standard is interlaced |
| std_525p_i | input | 1 | Active standard is 525p |
| sd_vsync_i | input | 1 | SD VSYNC/field signal |
| edhd_vsync_i | input | 1 | ED/HD VSYNC or field signal |
| code_f_i | input | 1 | F bit from embedded timing codes |
| code_v_i | input | 1 | V bit from embedded timing codes |
| line_cnt_i | input | LINE_W | ED/HD vertical line counter |
| vsync_o | output | 1 | Pipelined sync level for the pin |
| vsync_oe_o | output | 1 | Pipelined output enable for the three-state pin |

## Verification
The hardest situation to reach from the ports is a configuration that has been presented but not yet captured. A mid-frame change makes no visible difference until the next frame strobe, and even then it appears only after the pipeline drains.

The stimulus covers this in two ways. First, it sets up a live SD mode and then changes every configuration input without a strobe, holding for more than twice the pipeline depth; the old behaviour must persist. Second, it drops straight out of reset with an active configuration but no strobe, and the pin must stay three-stated. The main sweep pulses a strobe for each of the 16 configurations under each standard, then waits out the pipeline before comparing.

// File: rtl/vsync_sel_pkg.sv
package vsync_sel_pkg;

  typedef struct packed {
    logic edhd_en;
    logic sd_en;
    logic fmt;
    logic vctl;
  } vs_cfg_t;

  typedef enum logic [2:0] {
    M_HIZ     = 3'd0,
    M_SD      = 3'd1,
    M_PASS    = 3'd2,
    M_CODE    = 3'd3,
    M_COUNTER = 3'd4
  } vs_mode_e;

  // Priority: ED/HD enable wins over SD enable; counter select wins over format.
  function automatic vs_mode_e decode_mode(input vs_cfg_t c);
    vs_mode_e m;
    if (c.edhd_en) begin
      if (c.vctl)     m = M_COUNTER;
      else if (c.fmt) m = M_CODE;
      else            m = M_PASS;
    end else if (c.sd_en) begin
      m = M_SD;
    end else begin
      m = M_HIZ;
    end
    return m;
  endfunction

  function automatic logic in_span(input int unsigned line,
                                   input int unsigned lo,
                                   input int unsigned hi);
    return (line >= lo) && (line <= hi);
  endfunction

endpackage

// File: rtl/vsync_cfg_shadow.sv
module vsync_cfg_shadow
  import vsync_sel_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    load_i,
  input  vs_cfg_t cfg_i,
  output vs_cfg_t cfg_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (load_i) cfg_q <= cfg_i;
  end

endmodule

// File: rtl/vsync_src_mux.sv
module vsync_src_mux
  import vsync_sel_pkg::*;
#(
  parameter int LINE_W    = 11,
  parameter int VBI_FIRST = 1,
  parameter int VBI_LAST  = 42,
  parameter int SER_FIRST = 4,
  parameter int SER_LAST  = 6
) (
  input  vs_cfg_t            cfg_i,
  input  logic               std_interlaced_i,
  input  logic               std_525p_i,
  input  logic               sd_vsync_i,
  input  logic               edhd_vsync_i,
  input  logic               code_f_i,
  input  logic               code_v_i,
  input  logic [LINE_W-1:0]  line_cnt_i,
  output vs_mode_e           mode_o,
  output logic               sync_o,
  output logic               oe_o
);

  logic in_vbi;
  logic in_ser;
  logic counter_pulse;
  logic code_pulse;

  assign mode_o        = decode_mode(cfg_i);
  assign in_vbi        = in_span(int'(line_cnt_i), VBI_FIRST, VBI_LAST);
  assign in_ser        = in_span(int'(line_cnt_i), SER_FIRST, SER_LAST);
  assign counter_pulse = std_525p_i ? in_vbi : in_ser;
  assign code_pulse    = std_interlaced_i ? code_f_i : code_v_i;

  always_comb begin
    oe_o   = 1'b1;
    sync_o = 1'b0;
    unique case (mode_o)
      M_SD:      sync_o = sd_vsync_i;
      M_PASS:    sync_o = edhd_vsync_i;
      M_CODE:    sync_o = code_pulse;
      M_COUNTER: sync_o = counter_pulse;
      default:   oe_o   = 1'b0;
    endcase
  end

endmodule

// File: rtl/vsync_align_pipe.sv
module vsync_align_pipe #(
  parameter int WIDTH = 2,
  parameter int DEPTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage [DEPTH];

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      if (i == 0) begin : g_head
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage[0] <= '0;
          else        stage[0] <= d_i;
        end
      end else begin : g_tail
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage[i] <= '0;
          else        stage[i] <= stage[i-1];
        end
      end
    end
  endgenerate

  assign q_o = stage[DEPTH-1];

endmodule

// File: rtl/vsync_out_sel.sv
module vsync_out_sel
  import vsync_sel_pkg::*;
#(
  parameter int LINE_W    = 11,
  parameter int DEPTH     = 3,
  parameter int VBI_FIRST = 1,
  parameter int VBI_LAST  = 42,
  parameter int SER_FIRST = 4,
  parameter int SER_LAST  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start_i,
  input  logic              cfg_edhd_en_i,
  input  logic              cfg_sd_en_i,
  input  logic              cfg_fmt_i,
  input  logic              cfg_vctl_i,
  input  logic              std_interlaced_i,
  input  logic              std_525p_i,
  input  logic              sd_vsync_i,
  input  logic              edhd_vsync_i,
  input  logic              code_f_i,
  input  logic              code_v_i,
  input  logic [LINE_W-1:0] line_cnt_i,
  output logic              vsync_o,
  output logic              vsync_oe_o
);

  localparam int PIPE_W = 2;

  vs_cfg_t            cfg_d;
  vs_cfg_t            cfg_q;
  vs_mode_e           sel_mode;
  logic               sel_sync;
  logic               sel_oe;
  logic [PIPE_W-1:0]  pipe_out;

  assign cfg_d = '{edhd_en: cfg_edhd_en_i, sd_en: cfg_sd_en_i,
                   fmt: cfg_fmt_i, vctl: cfg_vctl_i};

  vsync_cfg_shadow u_shadow (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (frame_start_i),
    .cfg_i  (cfg_d),
    .cfg_q  (cfg_q)
  );

  vsync_src_mux #(
    .LINE_W    (LINE_W),
    .VBI_FIRST (VBI_FIRST),
    .VBI_LAST  (VBI_LAST),
    .SER_FIRST (SER_FIRST),
    .SER_LAST  (SER_LAST)
  ) u_mux (
    .cfg_i            (cfg_q),
    .std_interlaced_i (std_interlaced_i),
    .std_525p_i       (std_525p_i),
    .sd_vsync_i       (sd_vsync_i),
    .edhd_vsync_i     (edhd_vsync_i),
    .code_f_i         (code_f_i),
    .code_v_i         (code_v_i),
    .line_cnt_i       (line_cnt_i),
    .mode_o           (sel_mode),
    .sync_o           (sel_sync),
    .oe_o             (sel_oe)
  );

  vsync_align_pipe #(
    .WIDTH (PIPE_W),
    .DEPTH (DEPTH)
  ) u_pipe (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({sel_oe, sel_sync}),
    .q_o   (pipe_out)
  );

  assign vsync_oe_o = pipe_out[1];
  assign vsync_o    = pipe_out[0];

endmodule

// File: rtl/vsync_out_sel_chk.sv
module vsync_out_sel_chk
  import vsync_sel_pkg::*;
#(
  parameter int LINE_W    = 11,
  parameter int SER_FIRST = 4,
  parameter int SER_LAST  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_start_i,
  input logic              cfg_edhd_en_i,
  input logic              cfg_sd_en_i,
  input logic              cfg_fmt_i,
  input logic              cfg_vctl_i,
  input logic              std_525p_i,
  input logic [LINE_W-1:0] line_cnt_i,
  input vs_cfg_t           cfg_q,
  input vs_mode_e          sel_mode,
  input logic              sel_sync,
  input logic              sel_oe,
  input logic              vsync_o,
  input logic              vsync_oe_o
);

  p_cfg_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start_i |=> $stable(cfg_q));

  p_cfg_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_i |=> (cfg_q.edhd_en == $past(cfg_edhd_en_i)) &&
                      (cfg_q.sd_en   == $past(cfg_sd_en_i))   &&
                      (cfg_q.fmt     == $past(cfg_fmt_i))     &&
                      (cfg_q.vctl    == $past(cfg_vctl_i)));

  p_sd_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q.edhd_en |-> (sel_mode != M_SD) && (sel_mode != M_HIZ) && sel_oe);

  p_hiz_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_q.edhd_en && !cfg_q.sd_en) |-> (!sel_oe && !sel_sync));

  p_pin_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !vsync_oe_o |-> !vsync_o);

  p_ser_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_mode == M_COUNTER && !std_525p_i &&
     (int'(line_cnt_i) < SER_FIRST || int'(line_cnt_i) > SER_LAST)) |-> !sel_sync);

endmodule

bind vsync_out_sel vsync_out_sel_chk #(
  .LINE_W    (LINE_W),
  .SER_FIRST (SER_FIRST),
  .SER_LAST  (SER_LAST)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .frame_start_i (frame_start_i),
  .cfg_edhd_en_i (cfg_edhd_en_i),
  .cfg_sd_en_i   (cfg_sd_en_i),
  .cfg_fmt_i     (cfg_fmt_i),
  .cfg_vctl_i    (cfg_vctl_i),
  .std_525p_i    (std_525p_i),
  .line_cnt_i    (line_cnt_i),
  .cfg_q         (cfg_q),
  .sel_mode      (sel_mode),
  .sel_sync      (sel_sync),
  .sel_oe        (sel_oe),
  .vsync_o       (vsync_o),
  .vsync_oe_o    (vsync_oe_o)
);

// File: tb/vsync_out_sel_bench.sv
module vsync_out_sel_bench;

  localparam int LINE_W = 11;
  localparam int DEPTH  = 3;
  localparam int VB_LO  = 1;
  localparam int VB_HI  = 42;
  localparam int SR_LO  = 4;
  localparam int SR_HI  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_start_i = 1'b0;
  logic cfg_edhd_en_i = 1'b0, cfg_sd_en_i = 1'b0, cfg_fmt_i = 1'b0, cfg_vctl_i = 1'b0;
  logic std_interlaced_i = 1'b0, std_525p_i = 1'b0;
  logic sd_vsync_i = 1'b0, edhd_vsync_i = 1'b0, code_f_i = 1'b0, code_v_i = 1'b0;
  logic [LINE_W-1:0] line_cnt_i = '0;
  logic vsync_o, vsync_oe_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  vsync_out_sel #(
    .LINE_W(LINE_W), .DEPTH(DEPTH),
    .VBI_FIRST(VB_LO), .VBI_LAST(VB_HI), .SER_FIRST(SR_LO), .SER_LAST(SR_HI)
  ) u_vsync_out_sel (
    .clk(clk), .rst_n(rst_n), .frame_start_i(frame_start_i),
    .cfg_edhd_en_i(cfg_edhd_en_i), .cfg_sd_en_i(cfg_sd_en_i),
    .cfg_fmt_i(cfg_fmt_i), .cfg_vctl_i(cfg_vctl_i),
    .std_interlaced_i(std_interlaced_i), .std_525p_i(std_525p_i),
    .sd_vsync_i(sd_vsync_i), .edhd_vsync_i(edhd_vsync_i),
    .code_f_i(code_f_i), .code_v_i(code_v_i), .line_cnt_i(line_cnt_i),
    .vsync_o(vsync_o), .vsync_oe_o(vsync_oe_o)
  );

  // Expected {oe, sync} restated from the requirements.
  function automatic logic [1:0] model(input logic [3:0] c, input logic il, input logic p5,
                                       input logic [3:0] src, input int line);
    logic e, s, f, v;
    {e, s, f, v} = c;
    if (!e && !s) return 2'b00;
    if (!e)       return {1'b1, src[3]};
    if (v)        return {1'b1, p5 ? (line >= VB_LO && line <= VB_HI)
                                   : (line >= SR_LO && line <= SR_HI)};
    if (f)        return {1'b1, il ? src[1] : src[0]};
    return {1'b1, src[2]};
  endfunction

  function automatic string tag_of(input logic [3:0] c, input logic il, input logic p5);
    string t;
    if (!c[3]) t = c[2] ? "R3" : "R2";
    else if (c[0]) t = p5 ? "R8" : "R9";
    else if (c[1]) t = il ? "R6" : "R7";
    else t = "R5";
    if (c[3] && c[2]) t = {t, "/R4"};
    return t;
  endfunction

  task automatic check(input string tag, input logic [1:0] got, input logic [1:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got oe/sync=%b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic settle();
    repeat (DEPTH + 1) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_cfg(input logic [3:0] c);
    @(negedge clk);
    {cfg_edhd_en_i, cfg_sd_en_i, cfg_fmt_i, cfg_vctl_i} = c;
    frame_start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    frame_start_i = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: got no finish expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R1: in reset, with an active configuration and input presented
    {cfg_edhd_en_i, cfg_sd_en_i, cfg_fmt_i, cfg_vctl_i} = 4'b0100;
    sd_vsync_i = 1'b1;
    frame_start_i = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 in reset", {vsync_oe_o, vsync_o}, 2'b00);
    frame_start_i = 1'b0;
    rst_n = 1'b1;
    repeat (2 * DEPTH + 2) @(posedge clk);
    @(negedge clk);
    check("R1 before first strobe", {vsync_oe_o, vsync_o}, 2'b00);

    // Near-exhaustive sweep: configurations x standards x sources (x lines)
    for (int c = 0; c < 16; c++) begin
      for (int st = 0; st < 3; st++) begin
        std_interlaced_i = st[0];
        std_525p_i = st[1];
        set_cfg(4'(c));
        for (int src = 0; src < 16; src++) begin
          {sd_vsync_i, edhd_vsync_i, code_f_i, code_v_i} = 4'(src);
          line_cnt_i = LINE_W'(src);
          settle();
          check(tag_of(4'(c), st[0], st[1]), {vsync_oe_o, vsync_o},
                model(4'(c), st[0], st[1], 4'(src), src));
        end
        if (c[3] && c[0]) begin
          for (int ln = 0; ln < 64; ln++) begin
            line_cnt_i = LINE_W'(ln);
            {sd_vsync_i, edhd_vsync_i, code_f_i, code_v_i} = 4'(ln);
            settle();
            check(tag_of(4'(c), st[0], st[1]), {vsync_oe_o, vsync_o},
                  model(4'(c), st[0], st[1], 4'(ln), ln));
          end
        end
      end
    end

    // R10: exact pipeline latency in SD mode
    set_cfg(4'b0100);
    sd_vsync_i = 1'b0;
    settle();
    sd_vsync_i = 1'b1;
    repeat (DEPTH - 1) @(posedge clk);
    @(negedge clk);
    check("R10 one edge early", {vsync_oe_o, vsync_o}, 2'b10);
    @(posedge clk);
    @(negedge clk);
    check("R10 on time", {vsync_oe_o, vsync_o}, 2'b11);

    // R11: configuration change without a strobe has no effect
    {cfg_edhd_en_i, cfg_sd_en_i, cfg_fmt_i, cfg_vctl_i} = 4'b0000;
    repeat (2 * DEPTH + 2) @(posedge clk);
    @(negedge clk);
    check("R11 held without strobe", {vsync_oe_o, vsync_o}, 2'b11);
    {cfg_edhd_en_i, cfg_sd_en_i, cfg_fmt_i, cfg_vctl_i} = 4'b1011;
    std_525p_i = 1'b0;
    line_cnt_i = LINE_W'(SR_LO);
    sd_vsync_i = 1'b0;
    repeat (2 * DEPTH + 2) @(posedge clk);
    @(negedge clk);
    check("R11 held without strobe 2", {vsync_oe_o, vsync_o}, 2'b10);
    set_cfg(4'b1011);
    settle();
    check("R11 applied at strobe", {vsync_oe_o, vsync_o}, 2'b11);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule